// File: doc/BRIEF.md
# Sampling-Clock Phase Aligner

This block drives the conversion strobe of an external A/D converter whose sampling interval can be changed from one sample to the next. The converter digitises a sinusoid whose frequency is exactly the nominal sample rate divided by a fixed integer N of at least 2. When the strobes are phase-aligned, every Nth sample falls on a zero crossing and reads zero. A constant timing lag τ turns each of those samples into the nonzero constant sin(2π·f0·τ).

The block keeps one returned sample out of every N. Each kept sample is treated, through the small-angle approximation, as a linear measure of τ. The block turns that measure into a whole number of clock ticks and lengthens or shortens exactly one later sampling interval by that amount. After that interval, the spacing goes back to the nominal period. There is no loop filter and no oscillator: each correction is a single one-shot step. A lock flag reports when the kept samples have stayed small for a programmable number of frames in a row.

Top module: `samp_phase_lock`

## Requirements
- R1: While reset is held, strobe_o and locked_o are 0 and phase_err_o is 0. After reset is released, the first strobe is seen in cycle Ts, counting the first rising edge with reset high as cycle 1. While no correction is pending, strobes then repeat every Ts cycles, where Ts = period_i.
- R2: strobe_o is high for exactly one clock cycle per sample.
- R3: The first valid sample after reset is kept, and so is every Nth valid sample after it (N = N_DIV). phase_err_o takes the kept value on the clock edge that captures it and holds that value until the next kept sample.
- R4: A cycle with sample_valid_i low is ignored. It does not advance the decimation count, and sample_i is not looked at in that cycle.
- R5: For a kept sample s (two's complement, SAMPLE_W bits), the correction in ticks is c = floor((s·Ts·N·10430 + 2^(SH−1)) / 2^SH), with SH = 15 + SAMPLE_W. Here 10430 is 2^16/(2π) rounded.
- R6: c is clamped to the range −floor(Ts/2) to +floor(Ts/2) before it is applied.
- R7: A nonzero correction from a kept sample is applied to the interval that begins at the next strobe, which then lasts Ts − c cycles. Every interval after it lasts Ts again.
- R8: Between a kept sample that produces a correction and the end of the adjusted interval, no new correction is taken. Kept samples in that window still update phase_err_o and the lock state.
- R9: Each kept sample with |s| < thresh_i adds one to a count of consecutive frames, and locked_o rises when that count reaches lock_frames_i. A kept sample with |s| ≥ thresh_i clears the count, and locked_o drops on the edge that captures it.
- R10: With the converter sampling a sinusoid of period N·Ts under a constant lag of a few ticks, the kept samples after the first correction have a magnitude below thresh_i, and locked_o is set once lock_frames_i such frames have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | PERIOD_W | Nominal sampling interval Ts in clock ticks |
| thresh_i | input | SAMPLE_W | Magnitude threshold used for lock detection |
| lock_frames_i | input | LOCK_W | Number of consecutive in-threshold frames needed for lock |
| sample_i | input | SAMPLE_W | Signed sample returned by the converter |
| sample_valid_i | input | 1 | Marks the cycle in which sample_i is valid |
| strobe_o | output | 1 | One-cycle conversion strobe |
| locked_o | output | 1 | Phase-lock indication |
| phase_err_o | output | SAMPLE_W | Last kept (decimated) sample, signed |

## Verification
The bench builds the block with its defaults: 12-bit samples, a 16-bit period field, N = 4 and an 8-bit lock counter. It runs at Ts = 100 ticks. With these values a sample of ±161 maps to a correction of ±5 ticks, so a bench model that evaluates the sinusoid at the real strobe times can show one-step convergence for lags of +5 and −7 ticks. Full-scale samples reach the ±50-tick clamp. Because N = 4, short bursts of valid and invalid cycles can place a kept sample inside a pending correction window, or move a kept sample if invalid cycles were ever counted.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // 2^16 / (2*pi), rounded
  localparam int INV_2PI_Q16 = 10430;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ACTIVE
  } corr_st_e;
endpackage

// File: rtl/spl_interval_timer.sv
module spl_interval_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] len_i,
  output logic                end_o,
  output logic                strobe_o
);
  logic [PERIOD_W-1:0] cnt_q;

  // >= recovers if the length is reprogrammed below the running count
  assign end_o = (cnt_q >= len_i - PERIOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      cnt_q    <= end_o ? '0 : cnt_q + PERIOD_W'(1);
      strobe_o <= end_o;
    end
  end
endmodule

// File: rtl/spl_decim.sv
module spl_decim #(
  parameter int N_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic keep_o
);
  localparam int IDX_W = (N_DIV > 2) ? $clog2(N_DIV) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIV - 1);

  logic [IDX_W-1:0] idx_q;

  assign keep_o = valid_i && (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (valid_i) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/spl_corr_calc.sv
module spl_corr_calc
  import spl_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PERIOD_W = 16,
  parameter int N_DIV    = 4
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [PERIOD_W-1:0] period_i,
  output logic signed [PERIOD_W:0]   corr_o
);
  localparam int  K_GAIN = N_DIV * INV_2PI_Q16;
  localparam int  K_W    = $clog2(K_GAIN + 1) + 1;
  localparam int  PROD_W = SAMPLE_W + PERIOD_W + 1 + K_W;
  localparam int  SH     = 16 + SAMPLE_W - 1;
  localparam longint HALF_L = longint'(1) <<< (SH - 1);

  logic signed [PROD_W-1:0] s_ext, ts_ext, prod, rnd, lim, clamped;

  always_comb begin
    s_ext  = PROD_W'(sample_i);
    ts_ext = $signed(PROD_W'({1'b0, period_i}));
    prod   = s_ext * ts_ext * PROD_W'(K_GAIN);
    rnd    = (prod + PROD_W'(HALF_L)) >>> SH;
    lim    = $signed(PROD_W'(period_i >> 1));
    if (rnd > lim)       clamped = lim;
    else if (rnd < -lim) clamped = -lim;
    else                 clamped = rnd;
    corr_o = (PERIOD_W+1)'(clamped);
  end
endmodule

// File: rtl/spl_lock_det.sv
module spl_lock_det #(
  parameter int SAMPLE_W = 12,
  parameter int LOCK_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       keep_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  input  logic        [LOCK_W-1:0]   frames_i,
  output logic                       locked_o
);
  logic signed [SAMPLE_W:0] sx;
  logic        [SAMPLE_W:0] mag;
  logic                     below;
  logic        [LOCK_W-1:0] cnt_q;
  logic        [LOCK_W:0]   cnt_nx;

  always_comb begin
    sx     = {sample_i[SAMPLE_W-1], sample_i};
    mag    = sx[SAMPLE_W] ? unsigned'(-sx) : unsigned'(sx);
    below  = mag < {1'b0, thresh_i};
    cnt_nx = {1'b0, cnt_q} + (LOCK_W+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (keep_i) begin
      if (below) begin
        cnt_q <= (&cnt_q) ? cnt_q : cnt_nx[LOCK_W-1:0];
        if (cnt_nx >= {1'b0, frames_i}) locked_o <= 1'b1;
      end else begin
        cnt_q    <= '0;
        locked_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/samp_phase_lock.sv
module samp_phase_lock
  import spl_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PERIOD_W = 16,
  parameter int N_DIV    = 4,
  parameter int LOCK_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic        [PERIOD_W-1:0] period_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  input  logic        [LOCK_W-1:0]   lock_frames_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_valid_i,
  output logic                       strobe_o,
  output logic                       locked_o,
  output logic signed [SAMPLE_W-1:0] phase_err_o
);
  corr_st_e            st_q;
  logic [PERIOD_W-1:0] adj_len_q;
  logic [PERIOD_W-1:0] cur_len;
  logic [PERIOD_W-1:0] adj_nx;
  logic signed [PERIOD_W:0] corr_w;
  logic keep_w, end_w, busy_w;

  spl_decim #(.N_DIV(N_DIV)) u_decim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(sample_valid_i),
    .keep_o (keep_w)
  );

  spl_corr_calc #(.SAMPLE_W(SAMPLE_W), .PERIOD_W(PERIOD_W), .N_DIV(N_DIV)) u_corr (
    .sample_i(sample_i),
    .period_i(period_i),
    .corr_o  (corr_w)
  );

  spl_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .len_i   (cur_len),
    .end_o   (end_w),
    .strobe_o(strobe_o)
  );

  spl_lock_det #(.SAMPLE_W(SAMPLE_W), .LOCK_W(LOCK_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .keep_i  (keep_w),
    .sample_i(sample_i),
    .thresh_i(thresh_i),
    .frames_i(lock_frames_i),
    .locked_o(locked_o)
  );

  assign busy_w  = (st_q != ST_IDLE);
  assign cur_len = (st_q == ST_ACTIVE) ? adj_len_q : period_i;
  assign adj_nx  = PERIOD_W'($signed({1'b0, period_i}) - corr_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      adj_len_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (keep_w && corr_w != '0) begin
          st_q      <= ST_ARMED;
          adj_len_q <= adj_nx;
        end
        ST_ARMED:  if (end_w) st_q <= ST_ACTIVE;  // adjusted interval starts now
        ST_ACTIVE: if (end_w) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_err_o <= '0;
    else if (keep_w) phase_err_o <= sample_i;
  end
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
  parameter int SAMPLE_W = 12,
  parameter int PERIOD_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [PERIOD_W-1:0]        period_i,
  input logic [SAMPLE_W-1:0]        thresh_i,
  input logic signed [SAMPLE_W-1:0] sample_i,
  input logic                       sample_valid_i,
  input logic                       strobe_o,
  input logic                       locked_o,
  input logic signed [SAMPLE_W-1:0] phase_err_o,
  input logic                       keep,
  input logic                       busy,
  input logic [PERIOD_W-1:0]        adj_len
);
  logic [31:0] gap_q;
  logic        seen_q;
  logic [SAMPLE_W:0] mag;

  always_comb mag = sample_i[SAMPLE_W-1] ? (SAMPLE_W+1)'(-{sample_i[SAMPLE_W-1], sample_i})
                                         : {1'b0, sample_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= strobe_o ? '0 : gap_q + 32'd1;
      if (strobe_o) seen_q <= 1'b1;
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_err_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(phase_err_o));

  assert_unlock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep && mag >= {1'b0, thresh_i}) |=> !locked_o);

  assert_lock_on_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(sample_valid_i));

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && keep) |=> $stable(adj_len));

  assert_gap_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && seen_q) |->
      (gap_q + 32'd1 >= 32'(period_i) - 32'(period_i >> 1)) &&
      (gap_q + 32'd1 <= 32'(period_i) + 32'(period_i >> 1)));
endmodule

bind samp_phase_lock spl_checker #(.SAMPLE_W(SAMPLE_W), .PERIOD_W(PERIOD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .period_i      (period_i),
  .thresh_i      (thresh_i),
  .sample_i      (sample_i),
  .sample_valid_i(sample_valid_i),
  .strobe_o      (strobe_o),
  .locked_o      (locked_o),
  .phase_err_o   (phase_err_o),
  .keep          (keep_w),
  .busy          (busy_w),
  .adj_len       (adj_len_q)
);

// File: tb/samp_phase_lock_tb_top.sv
module samp_phase_lock_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int SW = 12, PW = 16, ND = 4, LW = 8, TS = 100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [PW-1:0] period_i = PW'(TS);
  logic [SW-1:0] thresh_i = SW'(20);
  logic [LW-1:0] lock_frames_i = LW'(3);
  logic signed [SW-1:0] sample_i = '0;
  logic sample_valid_i = 1'b0;
  logic strobe_o, locked_o;
  logic signed [SW-1:0] phase_err_o;

  samp_phase_lock #(.SAMPLE_W(SW), .PERIOD_W(PW), .N_DIV(ND), .LOCK_W(LW)) dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0, checks = 0;
  int cyc = 0, n_strobe = 0, lat_cnt = 0, lag = 0;
  int st_t [0:63];
  int mdl_val [0:63];
  int mdl_pend = 0;
  bit adc_en = 0, wide_seen = 0, prev_strobe = 0, mdl_on = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_corr(longint s, longint ts);
    longint r = (s * ts * ND * 10430 + (longint'(1) <<< 26)) >>> 27;
    if (r > ts / 2) r = ts / 2;
    if (r < -(ts / 2)) r = -(ts / 2);
    return r;
  endfunction

  initial forever begin
    @(posedge clk_i);
    if (rst_ni) cyc++;
  end

  // strobe monitor and converter model
  initial forever begin
    @(negedge clk_i);
    if (mdl_on) begin sample_valid_i = 1'b0; mdl_on = 0; end
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0 && adc_en) begin
        sample_i = SW'(mdl_pend); sample_valid_i = 1'b1; mdl_on = 1;
      end
    end
    if (rst_ni && strobe_o) begin
      if (prev_strobe) wide_seen = 1;
      if (n_strobe < 64) st_t[n_strobe] = cyc;
      if (adc_en && n_strobe < 64) begin
        real ph;
        ph = 2.0 * 3.14159265358979 * real'(cyc - st_t[0] + lag) / real'(ND * TS);
        mdl_pend = int'(2047.0 * $sin(ph));
        mdl_val[n_strobe] = mdl_pend;
        lat_cnt = 3;
      end
      n_strobe++;
    end
    prev_strobe = strobe_o;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk_i);
    adc_en = 0; lat_cnt = 0; sample_valid_i = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    n_strobe = 0; wide_seen = 0; cyc = 0;
    chk("R1 strobe in reset", strobe_o, 0);
    chk("R1 locked in reset", locked_o, 0);
    chk("R1 phase_err in reset", phase_err_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic wait_strobes(int n);
    int k = 0;
    while (n_strobe < n && k < 5000) begin @(negedge clk_i); k++; end
    if (n_strobe < n) chk("timeout waiting for strobe", n_strobe, n);
  endtask

  task automatic send(int v);
    @(negedge clk_i);
    sample_i = SW'(v); sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); sample_i = SW'(999);
    end
  endtask

  task automatic t_reset_timing();
    do_reset();
    wait_strobes(4);
    chk("R1 first strobe cycle", st_t[0], TS);
    for (int i = 1; i < 4; i++) chk("R1 nominal interval", st_t[i] - st_t[i-1], TS);
    chk("R2 strobe one cycle wide", wide_seen, 0);
  endtask

  task automatic t_decim();
    do_reset();
    send(9);
    chk("R3 first valid kept", phase_err_o, 9);
    idle_junk(5);
    chk("R4 invalid ignored", phase_err_o, 9);
    send(700); idle_junk(2); send(701); send(702);
    chk("R3 non-kept samples dropped", phase_err_o, 9);
    idle_junk(3);
    send(-13);
    chk("R3 R4 Nth valid kept", phase_err_o, -13);
  endtask

  task automatic t_corr(int s);
    do_reset();
    wait_strobes(1);
    send(s);
    wait_strobes(4);
    chk("R7 interval before adjust", st_t[1] - st_t[0], TS);
    chk("R5 R7 adjusted interval", st_t[2] - st_t[1], TS - exp_corr(s, TS));
    chk("R7 back to nominal", st_t[3] - st_t[2], TS);
  endtask

  task automatic t_clamp(int s, int exp_len);
    do_reset();
    wait_strobes(1);
    send(s);
    wait_strobes(4);
    chk("R6 clamped interval", st_t[2] - st_t[1], exp_len);
    chk("R6 back to nominal", st_t[3] - st_t[2], TS);
  endtask

  task automatic t_busy();
    do_reset();
    wait_strobes(1);
    send(161); send(1); send(2); send(3);
    send(300);
    chk("R8 kept sample still reported", phase_err_o, 300);
    wait_strobes(5);
    chk("R8 first correction kept", st_t[2] - st_t[1], TS - exp_corr(161, TS));
    chk("R8 second correction dropped", st_t[3] - st_t[2], TS);
    chk("R8 nominal after", st_t[4] - st_t[3], TS);
  endtask

  task automatic group(int kept);
    send(kept); send(0); send(0); send(0);
  endtask

  task automatic t_lock();
    do_reset();
    thresh_i = SW'(20); lock_frames_i = LW'(3);
    send(5);
    chk("R9 one frame not locked", locked_o, 0);
    send(0); send(0); send(0);
    group(-5);
    chk("R9 two frames not locked", locked_o, 0);
    group(19);
    chk("R9 locked after three frames", locked_o, 1);
    send(20);
    chk("R9 unlock at threshold", locked_o, 0);
    send(0); send(0); send(0);
    group(3);
    chk("R9 count restarted", locked_o, 0);
  endtask

  task automatic t_converge(int l);
    do_reset();
    lag = l; thresh_i = SW'(20); lock_frames_i = LW'(2); adc_en = 1;
    wait_strobes(9);
    repeat (6) @(negedge clk_i);
    chk("R10 initial error above threshold", (mdl_val[0] > 20 || mdl_val[0] < -20), 1);
    chk("R10 frame after correction", (mdl_val[4] < 20 && mdl_val[4] > -20), 1);
    chk("R10 second frame", (mdl_val[8] < 20 && mdl_val[8] > -20), 1);
    chk("R10 phase_err tracks", phase_err_o, mdl_val[8]);
    chk("R10 locked", locked_o, 1);
    adc_en = 0;
  endtask

  initial begin
    t_reset_timing();
    t_decim();
    t_corr(161);
    t_corr(-161);
    t_clamp(2047, TS - int'(exp_corr(2047, TS)));
    t_clamp(-2048, TS - int'(exp_corr(-2048, TS)));
    chk("R6 clamp bound", exp_corr(2047, TS), TS / 2);
    t_busy();
    t_lock();
    t_converge(5);
    t_converge(-7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule